// File: doc/BRIEF.md
# Bitfield Extract Unit with Condition Flags

This block pulls a contiguous run of bits out of a 32-bit source word and returns it right-aligned in a registered 32-bit result. A single 32-bit control word carries the placement of the field: its low byte gives the lowest bit of the field and its next byte gives the number of bits. A mode input picks how the bits above the field are filled. In unsigned mode they are filled with zeros. In signed mode they copy the top bit of the field.

Fields that do not fit the source word have defined results. A zero length gives zero. A field that starts at bit 32 or higher is empty. A field that runs past bit 31 is cut off at bit 31.

When the flag enable is high, the unit also updates four registered condition flags. Zero and sign are taken from the new result, and carry and overflow are cleared. When the flag enable is low, the flags keep their previous values. Results and flags load on a rising clock edge only when the input strobe is high.

Top module: `bitfield_extract_unit`

## Requirements
- R1: The field start is ctrlWord[7:0] and the field length is ctrlWord[15:8], both unsigned, and ctrlWord[31:16] has no effect. In unsigned mode (signedSel=0), a field that lies fully inside bits 31..0 appears at resultOut bit 0 upward, and all higher bits are zero.
- R2: In signed mode (signedSel=1), every result bit above the field equals the field's most significant bit.
- R3: A length of zero gives a result of zero, whatever the source, start and mode.
- R4: A start of 32 or more with a non-zero length gives zero in unsigned mode. In signed mode it gives 32 copies of srcData[31].
- R5: When start plus length is greater than 32, the field covers bits start..31 only. In signed mode its top bit is srcData[31].
- R6: resultOut and the flags load on the rising clock edge when inValid is 1. When inValid is 0 they hold their values.
- R7: A load with flagEn=1 sets flagZero to 1 exactly when the new 32-bit result is zero.
- R8: A load with flagEn=1 sets flagSign to bit 31 of the new result.
- R9: A load with flagEn=1 clears flagCarry and flagOvf.
- R10: A load with flagEn=0 updates resultOut but leaves all four flags unchanged.
- R11: An active-low asynchronous reset (rstN) clears resultOut and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Load strobe for the result and flag registers |
| srcData | input | 32 | Source word the field is taken from |
| ctrlWord | input | 32 | Bits [7:0] give the start, bits [15:8] give the length |
| signedSel | input | 1 | 1 selects sign fill, 0 selects zero fill |
| flagEn | input | 1 | 1 updates the flags on a load |
| resultOut | output | 32 | Registered right-aligned field |
| flagZero | output | 1 | Result was zero |
| flagSign | output | 1 | Result bit 31 |
| flagCarry | output | 1 | Carry flag, cleared on a flagged load |
| flagOvf | output | 1 | Overflow flag, cleared on a flagged load |

## Verification
Every result and flag is visible one clock after its load strobe. A misclassified field would show up on the next edge: a zero length or a too-high start taken as a normal field, or a truncated field given the wrong width. It would appear as wrong upper bits in resultOut, most clearly in signed mode, where the fill bit shows the decoded top index. A flag register that loads when it should hold, or fails to load, shows its error at the first load with the opposite flagEn value. The bench therefore mixes flagged and unflagged loads with idle cycles.

// File: rtl/bfe_pkg.sv
package bfe_pkg;

  typedef enum logic [1:0] {
    FM_NORMAL = 2'd0,
    FM_ZERO   = 2'd1,
    FM_FILL   = 2'd2
  } fieldMode_t;

  typedef struct packed {
    logic loadResult;
    logic loadFlags;
  } bfeStrobe_t;

endpackage

// File: rtl/bfe_control.sv
module bfe_control
  import bfe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = 8,
  parameter int LEN_W  = 8,
  parameter int CTRL_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int IDX_W = SH_W + 1
) (
  input  logic              inValid,
  input  logic              flagEn,
  input  logic [CTRL_W-1:0] ctrlWord,
  output bfeStrobe_t        strobe,
  output fieldMode_t        mode,
  output logic [SH_W-1:0]   shiftAmt,
  output logic [IDX_W-1:0]  effLen
);

  logic [POS_W-1:0] startPos;
  logic [LEN_W-1:0] fieldLen;
  logic             posOver;
  logic             lenZero;
  logic             lenOver;
  logic [IDX_W-1:0] remainBits;
  logic             ctrlUnused;

  assign startPos   = ctrlWord[POS_W-1:0];
  assign fieldLen   = ctrlWord[POS_W+LEN_W-1:POS_W];
  assign ctrlUnused = ^ctrlWord[CTRL_W-1:POS_W+LEN_W];

  assign posOver    = startPos >= POS_W'(DATA_W);
  assign lenZero    = fieldLen == '0;
  assign remainBits = IDX_W'(DATA_W) - {1'b0, startPos[SH_W-1:0]};
  assign lenOver    = fieldLen > LEN_W'(remainBits);

  always_comb begin
    shiftAmt = startPos[SH_W-1:0];
    effLen   = lenOver ? remainBits : fieldLen[IDX_W-1:0];
    if (lenZero)      mode = FM_ZERO;
    else if (posOver) mode = FM_FILL;
    else              mode = FM_NORMAL;
  end

  assign strobe.loadResult = inValid;
  assign strobe.loadFlags  = inValid & flagEn;

endmodule

// File: rtl/bfe_datapath.sv
module bfe_datapath
  import bfe_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int IDX_W = SH_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bfeStrobe_t        strobe,
  input  fieldMode_t        mode,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [IDX_W-1:0]  effLen,
  input  logic              signedSel,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] resultOut,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagCarry,
  output logic              flagOvf
);

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] maskVec;
  logic [IDX_W-1:0]  topIdx;
  logic              fieldTop;
  logic              fillBit;
  logic [DATA_W-1:0] extended;
  logic [DATA_W-1:0] nextResult;

  assign shifted = srcData >> shiftAmt;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
    assign maskVec[gi] = IDX_W'(gi) < effLen;
  end

  assign topIdx   = effLen - 1'b1;
  assign fieldTop = shifted[topIdx[SH_W-1:0]];
  assign fillBit  = signedSel & fieldTop;
  assign extended = (shifted & maskVec) | ({DATA_W{fillBit}} & ~maskVec);

  always_comb begin
    unique case (mode)
      FM_ZERO: nextResult = '0;
      FM_FILL: nextResult = {DATA_W{signedSel & srcData[DATA_W-1]}};
      default: nextResult = extended;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
    end else if (strobe.loadResult) begin
      resultOut <= nextResult;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagZero  <= 1'b0;
      flagSign  <= 1'b0;
      flagCarry <= 1'b0;
      flagOvf   <= 1'b0;
    end else if (strobe.loadFlags) begin
      flagZero  <= nextResult == '0;
      flagSign  <= nextResult[DATA_W-1];
      flagCarry <= 1'b0;
      flagOvf   <= 1'b0;
    end
  end

endmodule

// File: rtl/bitfield_extract_unit.sv
module bitfield_extract_unit
  import bfe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = 8,
  parameter int LEN_W  = 8,
  parameter int CTRL_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int IDX_W = SH_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcData,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              signedSel,
  input  logic              flagEn,
  output logic [DATA_W-1:0] resultOut,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagCarry,
  output logic              flagOvf
);

  bfeStrobe_t       strobe;
  fieldMode_t       mode;
  logic [SH_W-1:0]  shiftAmt;
  logic [IDX_W-1:0] effLen;

  bfe_control #(
    .DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W), .CTRL_W(CTRL_W)
  ) u_ctrl (
    .inValid (inValid),
    .flagEn  (flagEn),
    .ctrlWord(ctrlWord),
    .strobe  (strobe),
    .mode    (mode),
    .shiftAmt(shiftAmt),
    .effLen  (effLen)
  );

  bfe_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .mode     (mode),
    .shiftAmt (shiftAmt),
    .effLen   (effLen),
    .signedSel(signedSel),
    .srcData  (srcData),
    .resultOut(resultOut),
    .flagZero (flagZero),
    .flagSign (flagSign),
    .flagCarry(flagCarry),
    .flagOvf  (flagOvf)
  );

endmodule

// File: rtl/bfe_checker.sv
module bfe_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] ctrlWord,
  input logic        signedSel,
  input logic        flagEn,
  input logic [31:0] resultOut,
  input logic        flagZero,
  input logic        flagSign,
  input logic        flagCarry,
  input logic        flagOvf
);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(resultOut));

  // R3
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrlWord[15:8] == 8'd0) |=> resultOut == 32'd0);

  // R4
  empty_unsigned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrlWord[7:0] >= 8'd32 && ctrlWord[15:8] != 8'd0 && !signedSel)
      |=> resultOut == 32'd0);

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && flagEn) |=> flagZero == (resultOut == 32'd0));

  // R8
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && flagEn) |=> flagSign == resultOut[31]);

  // R9
  carry_ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && flagEn) |=> (!flagCarry && !flagOvf));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && flagEn) |=> $stable({flagZero, flagSign, flagCarry, flagOvf}));

  // R11
  always @(posedge clk) begin
    if (!rstN) begin
      reset_clear_chk: assert (resultOut == 32'd0 && !flagZero && !flagSign
                               && !flagCarry && !flagOvf);
    end
  end

endmodule

bind bitfield_extract_unit bfe_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .ctrlWord (ctrlWord),
  .signedSel(signedSel),
  .flagEn   (flagEn),
  .resultOut(resultOut),
  .flagZero (flagZero),
  .flagSign (flagSign),
  .flagCarry(flagCarry),
  .flagOvf  (flagOvf)
);

// File: tb/bitfield_extract_unit_tb.sv
module bitfield_extract_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcData = '0;
  logic [31:0] ctrlWord = '0;
  logic        signedSel = 1'b0;
  logic        flagEn = 1'b0;
  logic [31:0] resultOut;
  logic        flagZero, flagSign, flagCarry, flagOvf;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  logic [31:0] expRes = '0;
  logic [3:0]  expFlags = '0;

  always #5 clk = ~clk;

  bitfield_extract_unit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcData(srcData),
    .ctrlWord(ctrlWord), .signedSel(signedSel), .flagEn(flagEn),
    .resultOut(resultOut), .flagZero(flagZero), .flagSign(flagSign),
    .flagCarry(flagCarry), .flagOvf(flagOvf)
  );

  function automatic logic [31:0] model(logic [31:0] src, logic [31:0] ctl, logic sgn);
    int pos = int'(ctl[7:0]);
    int len = int'(ctl[15:8]);
    int eff;
    logic top;
    logic [31:0] r = '0;
    if (len == 0) return 32'd0;
    if (pos >= 32) return sgn ? {32{src[31]}} : 32'd0;
    eff = (pos + len > 32) ? 32 - pos : len;
    top = src[pos + eff - 1];
    for (int i = 0; i < 32; i++) begin
      if (i < eff) r[i] = src[pos + i];
      else         r[i] = sgn & top;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [31:0] src, logic [31:0] ctl,
                       logic sgn, logic fe, logic vld);
    srcData = src; ctrlWord = ctl; signedSel = sgn; flagEn = fe; inValid = vld;
    if (vld) begin
      expRes = model(src, ctl, sgn);
      if (fe) expFlags = {expRes == 32'd0, expRes[31], 1'b0, 1'b0};
    end
    @(negedge clk);
    check(req, resultOut, expRes);
    check({req, " flags"}, {28'd0, flagZero, flagSign, flagCarry, flagOvf},
          {28'd0, expFlags});
    inValid = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R11: reset state
    @(negedge clk); @(negedge clk);
    check("R11", resultOut, 32'd0);
    check("R11 flags", {28'd0, flagZero, flagSign, flagCarry, flagOvf}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: plain unsigned field, upper control bits ignored
    apply("R1", 32'hDEADBEEF, 32'h0000_0804, 1'b0, 1'b1, 1'b1);
    check("R1 value", resultOut, 32'h0000_00EE);
    apply("R1", 32'hDEADBEEF, 32'hA5C3_0804, 1'b0, 1'b1, 1'b1);
    // R2: sign fill
    apply("R2", 32'hDEADBEEF, 32'h0000_0804, 1'b1, 1'b1, 1'b1);
    check("R2 value", resultOut, 32'hFFFF_FFEE);
    // R8: negative result sets sign flag
    check("R8", {31'd0, flagSign}, 32'd1);
    // R3: zero length
    apply("R3", 32'hFFFF_FFFF, 32'h0000_0003, 1'b1, 1'b1, 1'b1);
    check("R3 value", resultOut, 32'd0);
    // R7: zero flag set
    check("R7", {31'd0, flagZero}, 32'd1);
    // R4: start beyond width
    apply("R4", 32'h8000_0001, 32'h0000_0528, 1'b0, 1'b1, 1'b1);
    check("R4 value", resultOut, 32'd0);
    apply("R4", 32'h8000_0001, 32'h0000_0528, 1'b1, 1'b1, 1'b1);
    check("R4 value", resultOut, 32'hFFFF_FFFF);
    apply("R4", 32'h7000_0001, 32'h0000_01FF, 1'b1, 1'b1, 1'b1);
    // R5: truncation at bit 31
    apply("R5", 32'hB000_0000, 32'h0000_0A1C, 1'b1, 1'b1, 1'b1);
    check("R5 value", resultOut, 32'hFFFF_FFFB);
    apply("R5", 32'hB000_0000, 32'h0000_0A1C, 1'b0, 1'b1, 1'b1);
    check("R5 value", resultOut, 32'h0000_000B);
    apply("R5", 32'h1234_5678, 32'h0000_FF00, 1'b1, 1'b1, 1'b1);
    // R9: carry and overflow clear
    check("R9", {30'd0, flagCarry, flagOvf}, 32'd0);
    // R10: flags hold on unflagged load while result changes
    apply("R10", 32'h0000_0000, 32'h0000_0800, 1'b0, 1'b0, 1'b1);
    check("R10 value", resultOut, 32'd0);
    // R6: no load while strobe low
    apply("R6", 32'hFFFF_FFFF, 32'h0000_2000, 1'b1, 1'b1, 1'b0);
    check("R6 value", resultOut, 32'd0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] c = $urandom;
      c[7:0]  = 8'($urandom_range(0, 40));
      c[15:8] = ($urandom_range(0, 9) == 0) ? 8'd0 : 8'($urandom_range(1, 36));
      if ($urandom_range(0, 19) == 0) c[7:0] = 8'($urandom);
      apply(c[15:8] == 0 ? "R3" :
            c[7:0] >= 32 ? "R4" :
            (int'(c[7:0]) + int'(c[15:8]) > 32) ? "R5" : "R1 R2",
            $urandom, c, 1'($urandom), 1'($urandom), ($urandom_range(0, 4) != 0));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule